// File: doc/BRIEF.md
# Transmit Byte Queue with Free-Space Interrupt

This block buffers bytes between a host and a serial transmitter. The host loads bytes with a write strobe. The serializer takes the oldest byte from the head of the queue with a pop strobe. The usable depth is either a short or a long capacity, chosen by one configuration bit. The short capacity is half the long one; with the defaults these are 8 and 16 entries.

The block reports the number of free slots and flags for empty and ready. It also raises an interrupt request when the free space reaches a threshold. A 2-bit level code picks the threshold from four settings, and the setting depends on the selected depth. The request is only raised while the transmitter enable is high. It is computed each cycle from the current free count and is not held in a latch.

Occupancy is tracked by a three-state machine:
- **EMPTY**
- **PARTIAL**
- **FULL**

Transitions between the states:
- **LOAD**: EMPTY → PARTIAL, when a write is accepted.
- **DRAIN**: PARTIAL → EMPTY, when the count reaches zero.
- **FILL**: PARTIAL → FULL, when the count reaches capacity.
- **RELEASE**: FULL → PARTIAL, when a pop is accepted.
- **FLUSH**: any state → EMPTY, when the depth-select bit changes.

Top module: `txq_irq_top`

## Requirements
- R1: After reset the queue is empty, `empty`=1, `ready`=1, `free_cnt` equals the selected capacity (8 with `deep_sel`=0), and `irq` is 0 while `tx_en` is 0.
- R2: `deep_sel`=0 selects a capacity of 8 entries and `deep_sel`=1 selects 16 entries; `free_cnt` counts free slots of the selected capacity.
- R3: Bytes leave in the order they were accepted; `head_data` shows the oldest stored byte while the queue is not empty.
- R4: With capacity 8, `irq` (with `tx_en`=1) is high when the free slots are at least the threshold for `lvl_code`: 2'b00 needs 8, 2'b01 needs 4, 2'b10 needs 6, 2'b11 needs 1.
- R5: With capacity 16, the thresholds are: 2'b00 needs 16, 2'b01 needs 8, 2'b10 needs 12, 2'b11 needs 1.
- R6: `irq` is 0 whenever `tx_en` is 0. It follows `tx_en` and `free_cnt` combinationally in the same cycle, with no latching.
- R7: With `lvl_code`=2'b00, `irq` is high only when the queue is fully empty. The cycle after a single byte is accepted, the request drops.
- R8: A write while no slot is free is ignored: `free_cnt` stays 0 and the stored bytes come out unchanged.
- R9: A pop while the queue is empty has no effect; `empty` stays 1 and `free_cnt` stays at capacity.
- R10: A change of `deep_sel` discards all stored bytes within one cycle, leaving every slot of the new capacity free. Writes and pops in that cycle are ignored.
- R11: `empty` is 1 exactly when no byte is stored, and `ready` is 1 exactly when at least one slot is free.
- R12: A write and a pop in the same cycle are both accepted when the queue is neither empty nor full. When the queue is full only the pop is accepted, and when it is empty only the write is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 8 | Byte to store |
| pop | input | 1 | Serializer takes the head byte |
| tx_en | input | 1 | Transmitter enable, gates the interrupt |
| deep_sel | input | 1 | Capacity select: 0 = 8, 1 = 16 |
| lvl_code | input | 2 | Free-space threshold code |
| head_data | output | 8 | Oldest stored byte |
| free_cnt | output | 5 | Number of free slots |
| empty | output | 1 | No byte stored |
| ready | output | 1 | At least one slot free |
| irq | output | 1 | Free-space interrupt request |

## Verification
The bench walks every threshold code at both capacities, one write at a time, so that the order of the table is actually tested. A design that sorted the codes by value, or used the short-depth table at the long depth, would raise the request at the wrong fill level. Writes into a full queue and pops from an empty one are followed by a full drain, so a design that wrapped its pointers or counter would emit a stale or overwritten byte. The bench also switches the depth with bytes still stored and makes simultaneous write-and-pop cycles at the empty and full edges; a design that kept old data or accepted the blocked side would show a wrong free count.

// File: rtl/txq_pkg.sv
package txq_pkg;
    typedef enum logic [1:0] {
        OCC_EMPTY = 2'd0,
        OCC_PART  = 2'd1,
        OCC_FULL  = 2'd2
    } occ_state_t;

    typedef enum logic [1:0] {
        LVL_ALL     = 2'b00,
        LVL_HALF    = 2'b01,
        LVL_3Q      = 2'b10,
        LVL_ONE     = 2'b11
    } lvl_code_t;
endpackage

// File: rtl/txq_mem.sv
module txq_mem #(
    parameter int DATA_W    = 8,
    parameter int DEPTH_MAX = 16,
    localparam int PTR_W    = $clog2(DEPTH_MAX)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              deep,
    input  logic              push,
    input  logic              pull,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] head
);
    logic [DATA_W-1:0] slots [DEPTH_MAX];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;
    logic [PTR_W-1:0]  last_idx;

    // Wrap point follows the selected capacity.
    assign last_idx = deep ? PTR_W'(DEPTH_MAX - 1) : PTR_W'(DEPTH_MAX / 2 - 1);

    always_ff @(posedge clk) begin
        if (push) begin
            slots[wr_ptr] <= din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push) begin
                wr_ptr <= (wr_ptr == last_idx) ? '0 : wr_ptr + PTR_W'(1);
            end
            if (pull) begin
                rd_ptr <= (rd_ptr == last_idx) ? '0 : rd_ptr + PTR_W'(1);
            end
        end
    end

    assign head = slots[rd_ptr];
endmodule

// File: rtl/txq_occ_fsm.sv
module txq_occ_fsm
    import txq_pkg::*;
#(
    parameter int DEPTH_MAX = 16,
    localparam int CNT_W    = $clog2(DEPTH_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             wr_req,
    input  logic             rd_req,
    input  logic [CNT_W-1:0] cap,
    output logic             push,
    output logic             pull,
    output logic [CNT_W-1:0] count,
    output logic             empty,
    output logic             ready
);
    occ_state_t       state_q;
    occ_state_t       state_d;
    logic [CNT_W-1:0] count_d;

    // Acceptance: blocked side of the queue is dropped.
    always_comb begin
        push    = wr_req && (state_q != OCC_FULL) && !flush;
        pull    = rd_req && (state_q != OCC_EMPTY) && !flush;
        count_d = flush ? '0 : count + CNT_W'(push) - CNT_W'(pull);
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        if (flush) begin
            state_d = OCC_EMPTY;                     // FLUSH
        end else begin
            unique case (state_q)
                OCC_EMPTY: begin
                    if (push) begin
                        state_d = (count_d == cap) ? OCC_FULL : OCC_PART;   // LOAD
                    end
                end
                OCC_PART: begin
                    if (count_d == '0) begin
                        state_d = OCC_EMPTY;         // DRAIN
                    end else if (count_d == cap) begin
                        state_d = OCC_FULL;          // FILL
                    end
                end
                OCC_FULL: begin
                    if (pull) begin
                        state_d = OCC_PART;          // RELEASE
                    end
                end
                default: state_d = OCC_EMPTY;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= OCC_EMPTY;
            count   <= '0;
        end else begin
            state_q <= state_d;
            count   <= count_d;
        end
    end

    // Output decode.
    always_comb begin
        empty = 1'b0;
        ready = 1'b1;
        unique case (state_q)
            OCC_EMPTY: empty = 1'b1;
            OCC_PART:  ;
            OCC_FULL:  ready = 1'b0;
            default:   empty = 1'b1;
        endcase
    end
endmodule

// File: rtl/txq_level.sv
module txq_level
    import txq_pkg::*;
#(
    parameter int DEPTH_MAX = 16,
    localparam int CNT_W    = $clog2(DEPTH_MAX + 1)
) (
    input  logic [CNT_W-1:0] cap,
    input  logic [CNT_W-1:0] free_cnt,
    input  logic [1:0]       code,
    input  logic             tx_en,
    output logic             irq
);
    logic [CNT_W-1:0] thr;

    // Threshold table scales with capacity: all, half, three quarters, one.
    always_comb begin
        unique case (lvl_code_t'(code))
            LVL_ALL:  thr = cap;
            LVL_HALF: thr = cap >> 1;
            LVL_3Q:   thr = cap - (cap >> 2);
            LVL_ONE:  thr = CNT_W'(1);
            default:  thr = cap;
        endcase
        irq = tx_en && (free_cnt >= thr);
    end
endmodule

// File: rtl/txq_irq_top.sv
module txq_irq_top #(
    parameter int DATA_W    = 8,
    parameter int DEPTH_MAX = 16,
    localparam int CNT_W    = $clog2(DEPTH_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              pop,
    input  logic              tx_en,
    input  logic              deep_sel,
    input  logic [1:0]        lvl_code,
    output logic [DATA_W-1:0] head_data,
    output logic [CNT_W-1:0]  free_cnt,
    output logic              empty,
    output logic              ready,
    output logic              irq
);
    logic             deep_q;
    logic             flush;
    logic             push;
    logic             pull;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] cap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            deep_q <= 1'b0;
        end else begin
            deep_q <= deep_sel;
        end
    end

    assign flush    = deep_sel != deep_q;
    assign cap      = deep_q ? CNT_W'(DEPTH_MAX) : CNT_W'(DEPTH_MAX / 2);
    assign free_cnt = cap - count;

    txq_occ_fsm #(.DEPTH_MAX(DEPTH_MAX)) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .flush  (flush),
        .wr_req (wr_en),
        .rd_req (pop),
        .cap    (cap),
        .push   (push),
        .pull   (pull),
        .count  (count),
        .empty  (empty),
        .ready  (ready)
    );

    txq_mem #(.DATA_W(DATA_W), .DEPTH_MAX(DEPTH_MAX)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush),
        .deep  (deep_q),
        .push  (push),
        .pull  (pull),
        .din   (wr_data),
        .head  (head_data)
    );

    txq_level #(.DEPTH_MAX(DEPTH_MAX)) u_level (
        .cap      (cap),
        .free_cnt (free_cnt),
        .code     (lvl_code),
        .tx_en    (tx_en),
        .irq      (irq)
    );
endmodule

// File: rtl/txq_irq_chk.sv
module txq_irq_chk #(
    parameter int DATA_W    = 8,
    parameter int DEPTH_MAX = 16,
    localparam int CNT_W    = $clog2(DEPTH_MAX + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              pop,
    input logic              tx_en,
    input logic              deep_sel,
    input logic              deep_q,
    input logic [1:0]        lvl_code,
    input logic [DATA_W-1:0] head_data,
    input logic [CNT_W-1:0]  free_cnt,
    input logic              empty,
    input logic              ready,
    input logic              irq
);
    assert_irq_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |-> !irq);

    assert_full_write_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (free_cnt == '0 && wr_en && !pop && deep_sel == deep_q)
        |=> (free_cnt == '0 && $stable(head_data)));

    assert_empty_pop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !wr_en) |=> empty);

    assert_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (deep_sel != deep_q) |=> empty);

    assert_default_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && lvl_code == 2'b00) |-> (irq == empty));

    assert_ready_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ready == (free_cnt != '0));

    assert_cap_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        free_cnt <= (deep_q ? CNT_W'(DEPTH_MAX) : CNT_W'(DEPTH_MAX / 2)));
endmodule

bind txq_irq_top txq_irq_chk #(.DATA_W(DATA_W), .DEPTH_MAX(DEPTH_MAX)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .pop       (pop),
    .tx_en     (tx_en),
    .deep_sel  (deep_sel),
    .deep_q    (deep_q),
    .lvl_code  (lvl_code),
    .head_data (head_data),
    .free_cnt  (free_cnt),
    .empty     (empty),
    .ready     (ready),
    .irq       (irq)
);

// File: tb/txq_irq_top_tb.sv
module txq_irq_top_tb;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       pop = 1'b0;
    logic       tx_en = 1'b0;
    logic       deep_sel = 1'b0;
    logic [1:0] lvl_code = 2'b00;
    logic [7:0] head_data;
    logic [4:0] free_cnt;
    logic       empty;
    logic       ready;
    logic       irq;

    int n_cmp = 0;
    int n_bad = 0;
    int exp_cnt = 0;
    int exp_dep = 8;
    bit done = 0;
    logic [7:0] sb [$];

    always #(CLK_P/2) clk = ~clk;

    txq_irq_top u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .pop(pop),
        .tx_en(tx_en), .deep_sel(deep_sel), .lvl_code(lvl_code),
        .head_data(head_data), .free_cnt(free_cnt), .empty(empty),
        .ready(ready), .irq(irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int thr_of(input int dep, input int code);
        case (code)
            0: return dep;
            1: return dep / 2;
            2: return (dep * 3) / 4;
            default: return 1;
        endcase
    endfunction

    task automatic check_state(input string tag);
        int fr = exp_dep - exp_cnt;
        chk({tag, " free_cnt"}, int'(free_cnt), fr);
        chk("R11 empty", int'(empty), int'(exp_cnt == 0));
        chk("R11 ready", int'(ready), int'(fr > 0));
        chk({tag, " R6 irq"}, int'(irq),
            int'(tx_en && (fr >= thr_of(exp_dep, int'(lvl_code)))));
    endtask

    // Driver: applies one cycle of stimulus and books expected bytes.
    task automatic drive(input bit w, input logic [7:0] d, input bit p, input string tag);
        bit acc_w;
        bit acc_p;
        wr_en = w; wr_data = d; pop = p;
        acc_w = w && (exp_cnt < exp_dep);
        acc_p = p && (exp_cnt > 0);
        if (acc_w) sb.push_back(d);
        @(posedge clk); #2;
        wr_en = 1'b0; pop = 1'b0;
        exp_cnt = exp_cnt + int'(acc_w) - int'(acc_p);
        check_state(tag);
    endtask

    task automatic set_depth(input bit d);
        deep_sel = d;
        @(posedge clk); #2;
        exp_cnt = 0;
        exp_dep = d ? 16 : 8;
        sb.delete();
        check_state("R10 R2");
    endtask

    // Monitor: compares the head byte against the scoreboard on each accepted pop.
    always @(negedge clk) begin
        if (rst_n && pop && !empty) begin
            if (sb.size() == 0) begin
                chk("R3 unexpected pop", 1, 0);
            end else begin
                logic [7:0] e;
                e = sb.pop_front();
                chk("R3 head order", int'(head_data), int'(e));
            end
        end
    end

    task automatic sweep_levels(input string tag);
        for (int c = 0; c < 4; c++) begin
            lvl_code = 2'(c);
            #1;
            check_state(tag);
            for (int i = 0; i < exp_dep; i++) drive(1'b1, 8'(c * 32 + i + 1), 1'b0, tag);
            for (int i = 0; i < exp_dep; i++) drive(1'b0, 8'h00, 1'b1, tag);
        end
        lvl_code = 2'b00;
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 free_cnt", int'(free_cnt), 8);
        chk("R1 empty", int'(empty), 1);
        chk("R1 ready", int'(ready), 1);
        chk("R1 irq", int'(irq), 0);

        // R6 combinational enable gating
        tx_en = 1'b1; #1;
        chk("R6 irq on enable", int'(irq), 1);
        tx_en = 1'b0; #1;
        chk("R6 irq off", int'(irq), 0);
        tx_en = 1'b1; #1;

        // R7 default code: one byte removes the request
        drive(1'b1, 8'hA5, 1'b0, "R7");
        chk("R7 irq after one byte", int'(irq), 0);
        drive(1'b0, 8'h00, 1'b1, "R7");
        chk("R7 irq after drain", int'(irq), 1);

        // R4 capacity 8 threshold table
        sweep_levels("R4");

        // R8 write into full queue ignored
        for (int i = 0; i < 8; i++) drive(1'b1, 8'(8'h40 + i), 1'b0, "R8");
        drive(1'b1, 8'hEE, 1'b0, "R8");
        drive(1'b1, 8'hEF, 1'b0, "R8");
        for (int i = 0; i < 8; i++) drive(1'b0, 8'h00, 1'b1, "R8");

        // R9 pop on empty queue
        drive(1'b0, 8'h00, 1'b1, "R9");
        drive(1'b0, 8'h00, 1'b1, "R9");
        chk("R9 empty stays", int'(empty), 1);

        // R12 simultaneous write and pop
        drive(1'b1, 8'h55, 1'b1, "R12 empty");
        drive(1'b1, 8'h56, 1'b0, "R12");
        drive(1'b1, 8'h57, 1'b1, "R12 mid");
        drive(1'b1, 8'h58, 1'b1, "R12 mid");
        for (int i = 0; i < 6; i++) drive(1'b1, 8'(8'h60 + i), 1'b0, "R12");
        drive(1'b1, 8'h77, 1'b1, "R12 full");
        while (exp_cnt > 0) drive(1'b0, 8'h00, 1'b1, "R12");

        // R10 flush on depth change with data stored, R2 long capacity
        for (int i = 0; i < 5; i++) drive(1'b1, 8'(8'h90 + i), 1'b0, "R10");
        set_depth(1'b1);
        drive(1'b0, 8'h00, 1'b1, "R10 R9");

        // R5 capacity 16 threshold table
        sweep_levels("R5");

        // R6 disable gating at long capacity, then back to short
        tx_en = 1'b0; #1;
        check_state("R6");
        tx_en = 1'b1;
        for (int i = 0; i < 3; i++) drive(1'b1, 8'(8'hC0 + i), 1'b0, "R10");
        set_depth(1'b0);
        drive(1'b1, 8'hD1, 1'b0, "R2");
        drive(1'b0, 8'h00, 1'b1, "R3");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule